// File: doc/BRIEF.md
# Fetch-Execute Sequencer with Stall Watchdog

This block is a small control state machine that runs one simplified fetch-execute round per request. A pulse or level on `start` moves it out of its resting state into a fetch phase. In that phase it holds a memory read request up and waits for an operand word to arrive. Once the word is taken, it spends exactly one cycle in an execute phase. During that cycle it enables the downstream arithmetic unit, signals completion and presents the captured word. It then returns to rest.

A watchdog counts fetch cycles that pass without data. If the stall lasts too long, the sequencer drops into a halt state that reports an error. It leaves that state only after `start` has been released.

The operand arrives as a valid/ready stream. `mem_read` acts as the ready signal and is high only during the fetch phase. A word is transferred in a cycle where `fetch_valid` and `mem_read` are both high. `fetch_valid` in any other state is ignored, and no word is accepted then. The source may hold `fetch_valid` low for as long as it likes. The only price is the watchdog. The four states are one-hot: rest `4'b0001`, fetch `4'b0010`, execute `4'b0100`, halt `4'b1000`.

Top module: `fx_sequencer`

## Requirements
- R1: While `rst_n` is low, and asynchronously to the clock, the sequencer is at rest with every output at 0 and `exec_data` equal to 0.
- R2: At rest, `start`=0 keeps the sequencer at rest with all outputs low; `start`=1 moves it to fetch on the next edge.
- R3: `mem_read` is high exactly in the fetch state; a fetch cycle with `fetch_valid`=1 moves to execute on the next edge.
- R4: After exactly TIMEOUT_CYCLES consecutive fetch cycles with `fetch_valid`=0, the next state is halt. `error` is high combinationally during the last of those cycles, and low in earlier fetch cycles.
- R5: If `fetch_valid`=1 in the cycle where the stall limit is reached, the word is accepted, the next state is execute and `error` stays low in that cycle.
- R6: Execute lasts one cycle, with `alu_enable` and `done` both high, and is followed unconditionally by rest.
- R7: `exec_data` equals the `fetch_data` value accepted at the fetch-to-execute transition while in execute, and is 0 in every other state.
- R8: In halt, `halt` and `error` are high. The sequencer stays in halt while `start`=1 and returns to rest on the edge after a cycle with `start`=0.
- R9: The stall count restarts on every entry to fetch, so each fetch visit gets the full TIMEOUT_CYCLES budget regardless of earlier visits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to run a round; also holds halt while high |
| fetch_valid | input | 1 | Operand word valid (stream valid) |
| fetch_data | input | DATA_WIDTH | Operand word |
| mem_read | output | 1 | Memory request; stream ready, high in fetch |
| alu_enable | output | 1 | Arithmetic unit enable, high in execute |
| halt | output | 1 | High in the halt state |
| done | output | 1 | Round completion, high in execute |
| error | output | 1 | Stall error: halt state, or stall limit reached in fetch |
| exec_data | output | DATA_WIDTH | Captured operand during execute, else 0 |

## Verification
The bench aims at the exact stall boundary. If the watchdog were off by one, the sequencer would halt one cycle early, or would linger in fetch for an extra cycle with `error` raised late. It drives a word in exactly the cycle where the limit is reached. A design that let the timeout win there would raise `error` and lose the word. A second fetch visit follows one that came within a cycle of the limit. A design that did not clear the count between visits would halt on that second visit too soon. The bench also holds `start` high through halt, which catches a design that leaves halt on its own.

// File: rtl/fx_seq_pkg.sv
package fx_seq_pkg;
  typedef enum logic [3:0] {
    ST_REST  = 4'b0001,
    ST_FETCH = 4'b0010,
    ST_EXEC  = 4'b0100,
    ST_HALT  = 4'b1000
  } fx_state_e;
endpackage

// File: rtl/fx_stall_watchdog.sv
module fx_stall_watchdog #(
  parameter int TIMEOUT_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic hit,
  output logic expired
);
  localparam int CW = (TIMEOUT_CYCLES < 2) ? 1 : $clog2(TIMEOUT_CYCLES);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYCLES - 1);

  logic [CW-1:0] count_q;

  assign expired = armed && (count_q == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  count_q <= '0;
    else if (!armed)             count_q <= '0;
    else if (!hit && !expired)   count_q <= count_q + 1'b1;
  end

  // Count never passes the limit while armed
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= LIMIT);
  // Count is back at zero after any unarmed cycle
  assert_count_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> count_q == '0);
endmodule

// File: rtl/fx_operand_latch.sv
module fx_operand_latch #(
  parameter int DATA_WIDTH = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [DATA_WIDTH-1:0] din,
  input  logic                  show,
  output logic [DATA_WIDTH-1:0] dout
);
  logic [DATA_WIDTH-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '0;
    else if (load) word_q <= din;
  end

  assign dout = show ? word_q : '0;

  assert_hidden_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !show |-> dout == '0);
endmodule

// File: rtl/fx_sequencer.sv
module fx_sequencer
  import fx_seq_pkg::*;
#(
  parameter int DATA_WIDTH     = 32,
  parameter int TIMEOUT_CYCLES = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  fetch_valid,
  input  logic [DATA_WIDTH-1:0] fetch_data,
  output logic                  mem_read,
  output logic                  alu_enable,
  output logic                  halt,
  output logic                  done,
  output logic                  error,
  output logic [DATA_WIDTH-1:0] exec_data
);
  fx_state_e state_q, state_d;
  logic      in_fetch, in_exec, in_halt, stall_hit, take_word;

  assign in_fetch  = (state_q == ST_FETCH);
  assign in_exec   = (state_q == ST_EXEC);
  assign in_halt   = (state_q == ST_HALT);
  assign take_word = in_fetch && fetch_valid;

  fx_stall_watchdog #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_watchdog (
    .clk     (clk),
    .rst_n   (rst_n),
    .armed   (in_fetch),
    .hit     (fetch_valid),
    .expired (stall_hit)
  );

  fx_operand_latch #(.DATA_WIDTH(DATA_WIDTH)) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (take_word),
    .din   (fetch_data),
    .show  (in_exec),
    .dout  (exec_data)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_REST:  if (start) state_d = ST_FETCH;
      ST_FETCH: begin
        if (fetch_valid)    state_d = ST_EXEC;
        else if (stall_hit) state_d = ST_HALT;
      end
      ST_EXEC:  state_d = ST_REST;
      ST_HALT:  if (!start) state_d = ST_REST;
      default:  state_d = ST_REST;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_REST;
    else        state_q <= state_d;
  end

  assign mem_read   = in_fetch;
  assign alu_enable = in_exec;
  assign done       = in_exec;
  assign halt       = in_halt;
  assign error      = in_halt || (in_fetch && stall_hit && !fetch_valid);

  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state_q) == 1);
  assert_start_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_read && !alu_enable && !halt && start) |=> mem_read);
  assert_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_read && fetch_valid) |=> alu_enable);
  assert_stall_halt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_read && error) |=> halt);
  assert_valid_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_read && fetch_valid) |-> !error);
  assert_exec_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !mem_read && !halt));
  assert_exec_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    alu_enable |-> exec_data == $past(fetch_data));
  assert_halt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && start) |=> (halt && error));
  assert_halt_leave_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !start) |=> (!halt && !mem_read));
endmodule

// File: tb/tb_fx_sequencer.sv
`timescale 1ns/1ps
module tb_fx_sequencer;
  localparam int DW = 16;
  localparam int T  = 6;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          start = 1'b0, fetch_valid = 1'b0;
  logic [DW-1:0] fetch_data = '0;
  logic          mem_read, alu_enable, halt, done, error;
  logic [DW-1:0] exec_data;

  int checks = 0, failures = 0;
  int m_st = 0, m_cnt = 0;   // model: 0 rest, 1 fetch, 2 exec, 3 halt
  logic [DW-1:0] m_cap = '0;

  always #10 clk = ~clk;

  fx_sequencer #(.DATA_WIDTH(DW), .TIMEOUT_CYCLES(T)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .fetch_valid(fetch_valid),
    .fetch_data(fetch_data), .mem_read(mem_read), .alu_enable(alu_enable),
    .halt(halt), .done(done), .error(error), .exec_data(exec_data));

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, got, exp, $time);
    end
  endtask

  function automatic logic exp_error(input int st, input int cnt, input logic v);
    return (st == 3) || (st == 1 && cnt == T-1 && !v);
  endfunction

  function automatic int exp_next(input int st, input int cnt, input logic s, input logic v);
    case (st)
      0: return s ? 1 : 0;
      1: return v ? 2 : ((cnt == T-1) ? 3 : 1);
      2: return 0;
      default: return s ? 3 : 0;
    endcase
  endfunction

  // One cycle: drive inputs, check outputs against the model, advance model
  task automatic step(input logic s, input logic v, input logic [DW-1:0] d);
    int nx;
    @(negedge clk);
    start = s; fetch_valid = v; fetch_data = d;
    #1;
    chk("R3", "mem_read",   int'(mem_read),   int'(m_st == 1));
    chk("R6", "alu_enable", int'(alu_enable), int'(m_st == 2));
    chk("R6", "done",       int'(done),       int'(m_st == 2));
    chk("R8", "halt",       int'(halt),       int'(m_st == 3));
    chk("R4", "error",      int'(error),      int'(exp_error(m_st, m_cnt, v)));
    chk("R7", "exec_data",  int'(exec_data),  (m_st == 2) ? int'(m_cap) : 0);
    nx = exp_next(m_st, m_cnt, s, v);
    if (m_st == 1 && v) m_cap = d;
    m_cnt = (m_st == 1 && nx == 1) ? m_cnt + 1 : 0;
    m_st = nx;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #5;
    // R1: outputs low during reset, before any clock edge
    chk("R1", "mem_read",   int'(mem_read), 0);
    chk("R1", "alu_enable", int'(alu_enable), 0);
    chk("R1", "halt",       int'(halt), 0);
    chk("R1", "done",       int'(done), 0);
    chk("R1", "error",      int'(error), 0);
    chk("R1", "exec_data",  int'(exec_data), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R2: no start keeps rest, stray valid ignored
    step(0, 1, 16'h1111);
    step(0, 0, 16'h0);
    chk("R2", "mem_read stays low", int'(mem_read), 0);

    // R3/R6/R7: immediate accept
    step(1, 0, 16'h0);
    step(0, 1, 16'hA5A5);
    step(0, 0, 16'h0);
    chk("R7", "exec_data captured", int'(exec_data), 16'hA5A5);
    step(0, 0, 16'h0);

    // R4/R8: full stall, hold start through halt
    step(1, 0, 16'h0);
    for (int i = 0; i < T-1; i++) step(1, 0, 16'h0);
    chk("R4", "error not early", int'(error), 0);
    step(1, 0, 16'h0);
    chk("R4", "error at limit", int'(error), 1);
    step(1, 1, 16'h2222);
    chk("R8", "halt entered", int'(halt), 1);
    step(1, 0, 16'h0);
    step(0, 0, 16'h0);
    chk("R8", "halt still with start=0 cycle", int'(halt), 1);
    step(0, 0, 16'h0);
    chk("R8", "back to rest", int'(halt | error), 0);

    // R5: valid in the limit cycle wins
    step(1, 0, 16'h0);
    for (int i = 0; i < T-1; i++) step(0, 0, 16'h0);
    step(0, 1, 16'h5A3C);
    chk("R5", "error low on accept", int'(error), 0);
    step(0, 0, 16'h0);
    chk("R5", "execute after limit", int'(alu_enable), 1);
    chk("R5", "word kept", int'(exec_data), 16'h5A3C);
    step(0, 0, 16'h0);

    // R9: near-limit visit, then second visit keeps full budget
    step(1, 0, 16'h0);
    for (int i = 0; i < T-1; i++) step(0, 0, 16'h0);
    step(0, 1, 16'h0F0F);
    step(0, 0, 16'h0);
    step(1, 0, 16'h0);
    for (int i = 0; i < T-1; i++) step(0, 0, 16'h0);
    chk("R9", "still fetching", int'(mem_read), 1);
    chk("R9", "no early error", int'(error), 0);
    step(0, 0, 16'h0);
    chk("R9", "error at full budget", int'(error), 1);
    step(0, 0, 16'h0);
    step(0, 0, 16'h0);

    // Random mix
    for (int i = 0; i < 600; i++)
      step(($urandom % 3) != 0, ($urandom % 5) == 0, DW'($urandom));

    // R1: asynchronous reset mid-run
    step(1, 0, 16'h0);
    #3 rst_n = 1'b0;
    #1;
    chk("R1", "mem_read after async reset", int'(mem_read), 0);
    chk("R1", "error after async reset", int'(error), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule